// File: doc/BRIEF.md
# Two-Stage Memory Attribute Combiner

The block merges the memory type chosen by a first translation stage with the type chosen by a second stage. It produces the single attribute byte and shareability that the memory system applies to the access. The first-stage attribute is one byte: the high nibble describes outer cacheability and the low nibble inner cacheability. The second stage supplies a compact 4-bit type code, which the block first widens into the same byte form. Each stage also supplies a 2-bit shareability field.

After widening, the two types are resolved. If either side is a device type, the numerically smaller byte is taken. If both sides are normal memory, each nibble takes the weaker cacheability of the two. Allocation hints come from stage 1, and transient stage-1 hints are handled specially. A cache-disable override can then force normal results to fully non-cacheable. The shareability of the two stages is merged with outer taking priority. The result is registered and flagged valid one cycle after each valid input. There is no backpressure, so a new input can enter on every cycle.

Top module: `mem_attr_combiner`

## Requirements
- R1: `outValid` is high in exactly those cycles that follow a cycle with `inValid` high. After reset, `outValid`, `outAttr` and `outSh` are all zero.
- R2: Stage-2 codes 0000, 0001, 0010 and 0011 are device types and widen to the code shifted left by two (0x00, 0x04, 0x08, 0x0C).
- R3: Stage-2 codes 0100 and 1111 widen to write-back on both nibbles (0xCC). Codes 1000 and 1100 widen to non-cacheable on both nibbles (0x44). Every other code takes its outer class from bits [3:2] and its inner class from bits [1:0], using 01 = non-cacheable 0100, 10 = write-through 1000 and 11 = write-back 1100.
- R4: An attribute byte is a device type when its upper nibble is zero. If either the stage-1 byte or the widened stage-2 byte is a device type, the result is the smaller of the two unsigned values.
- R5: For normal memory, each nibble takes the following class: non-cacheable if either side's bits [3:2] are 01; otherwise write-through if either side's bits [3:2] are 10; otherwise write-back. A non-cacheable nibble is exactly 0100. A cacheable nibble carries the stage-1 hint bits [1:0].
- R6: A stage-1 nibble of 0001–0011 is promoted to write-through with the same low bits, and a nibble of 0101–0111 is promoted to write-back with the same low bits, before merging. If that promoted nibble's merged class is not non-cacheable, the class bits are replaced before the hint bits are OR-ed in: 0000 when the promoted stage-1 class is write-through, and 0100 when it is write-back.
- R7: When `cacheDisable` is set and the merged result is not a device type, the attribute becomes 0x44. Device results are unchanged.
- R8: The final shareability is outer (10) if either side is 10, otherwise inner (11) if either side is 11, otherwise non-shareable (00). The value 01 is never produced.
- R9: The stage-2 shareability counts as outer whenever the final attribute is a device type or exactly 0x44. Otherwise a stage-2 value of 01 counts as non-shareable.
- R10: Inputs arriving on back-to-back cycles each produce their own result in order. While `inValid` is low, `outAttr` and `outSh` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input fields are valid this cycle |
| s1Attr | input | 8 | Stage-1 attribute byte (outer nibble high, inner nibble low) |
| s1Sh | input | 2 | Stage-1 shareability |
| s2MemAttr | input | 4 | Stage-2 memory type code |
| s2Sh | input | 2 | Stage-2 descriptor shareability |
| cacheDisable | input | 1 | Force normal results to non-cacheable |
| outValid | output | 1 | Result valid |
| outAttr | output | 8 | Final attribute byte |
| outSh | output | 2 | Final shareability |

## Verification
The cache-disable override and the shareability rule interact within a single evaluation. When the override turns a normal result into 0x44, the stage-2 shareability has to become outer in that same cycle, whatever the descriptor held. The bench provokes this with write-back inputs, the override set and inner or reserved shareability on both sides. It expects outer shareability together with 0x44, while the same inputs with the override clear must return the descriptor's own shareability.

// File: rtl/memattr_pkg.sv
package memattr_pkg;
  localparam int NIB_W   = 4;
  localparam int ATTR_W  = 2 * NIB_W;
  localparam int NUM_NIB = ATTR_W / NIB_W;
  localparam int SH_W    = 2;
  localparam int CODE_W  = 4;

  localparam logic [NIB_W-1:0] NIB_NC = 4'b0100;
  localparam logic [NIB_W-1:0] NIB_WT = 4'b1000;
  localparam logic [NIB_W-1:0] NIB_WB = 4'b1100;

  localparam logic [SH_W-1:0] SH_NONE  = 2'b00;
  localparam logic [SH_W-1:0] SH_RSVD  = 2'b01;
  localparam logic [SH_W-1:0] SH_OUTER = 2'b10;
  localparam logic [SH_W-1:0] SH_INNER = 2'b11;

  localparam logic [ATTR_W-1:0] ATTR_NC_BOTH = {NIB_NC, NIB_NC};
  localparam logic [ATTR_W-1:0] ATTR_WB_BOTH = {NIB_WB, NIB_WB};

  typedef struct packed {
    logic capture;
  } ctlStrobe_t;

  function automatic logic isDevice(input logic [ATTR_W-1:0] a);
    return a[ATTR_W-1 -: NIB_W] == '0;
  endfunction

  function automatic logic [SH_W-1:0] shMerge(input logic [SH_W-1:0] a,
                                              input logic [SH_W-1:0] b);
    if (a == SH_OUTER || b == SH_OUTER) return SH_OUTER;
    if (a == SH_INNER || b == SH_INNER) return SH_INNER;
    return SH_NONE;
  endfunction
endpackage

// File: rtl/mac_s2_expand.sv
module mac_s2_expand
  import memattr_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [ATTR_W-1:0] attr
);
  function automatic logic [NIB_W-1:0] classNib(input logic [1:0] c);
    case (c)
      2'b10:   return NIB_WT;
      2'b11:   return NIB_WB;
      default: return NIB_NC;
    endcase
  endfunction

  always_comb begin
    case (code)
      4'b0000, 4'b0001, 4'b0010, 4'b0011:
        attr = ATTR_W'({code[1:0], 2'b00});
      4'b0100, 4'b1111:
        attr = ATTR_WB_BOTH;
      4'b1000, 4'b1100:
        attr = ATTR_NC_BOTH;
      default:
        attr = {classNib(code[3:2]), classNib(code[1:0])};
    endcase
  end
endmodule

// File: rtl/mac_nibble_merge.sv
module mac_nibble_merge
  import memattr_pkg::*;
(
  input  logic [NIB_W-1:0] s1Nib,
  input  logic [NIB_W-1:0] s2Nib,
  output logic [NIB_W-1:0] merged
);
  logic             transient;
  logic [NIB_W-1:0] promoted;
  logic [1:0]       s1Cls;
  logic [1:0]       s2Cls;
  logic [NIB_W-1:0] base;

  assign transient = !s1Nib[3] && (s1Nib[1:0] != 2'b00);
  assign promoted  = transient ? {1'b1, s1Nib[2], s1Nib[1:0]} : s1Nib;
  assign s1Cls     = promoted[3:2];
  assign s2Cls     = s2Nib[3:2];

  always_comb begin
    if (s1Cls == NIB_NC[3:2] || s2Cls == NIB_NC[3:2])      base = NIB_NC;
    else if (s1Cls == NIB_WT[3:2] || s2Cls == NIB_WT[3:2]) base = NIB_WT;
    else                                                   base = NIB_WB;

    if (base == NIB_NC) begin
      merged = NIB_NC;
    end else begin
      if (transient) base = (s1Cls == NIB_WT[3:2]) ? '0 : NIB_NC;
      merged = base | {2'b00, promoted[1:0]};
    end
  end
endmodule

// File: rtl/mac_control.sv
module mac_control
  import memattr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output ctlStrobe_t strobe,
  output logic       outValid
);
  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import memattr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ATTR_W-1:0] s1Attr,
  input  logic [SH_W-1:0]   s1Sh,
  input  logic [CODE_W-1:0] s2MemAttr,
  input  logic [SH_W-1:0]   s2Sh,
  input  logic              cacheDisable,
  output logic [ATTR_W-1:0] outAttr,
  output logic [SH_W-1:0]   outSh
);
  logic [ATTR_W-1:0] s2Exp;
  logic [ATTR_W-1:0] normAttr;
  logic [ATTR_W-1:0] mergedAttr;
  logic [ATTR_W-1:0] finalAttr;
  logic [SH_W-1:0]   s2ShEff;
  logic [SH_W-1:0]   shFinal;
  logic              eitherDev;

  mac_s2_expand u_expand (
    .code (s2MemAttr),
    .attr (s2Exp)
  );

  for (genvar g = 0; g < NUM_NIB; g++) begin : gNib
    mac_nibble_merge u_merge (
      .s1Nib  (s1Attr[g*NIB_W +: NIB_W]),
      .s2Nib  (s2Exp[g*NIB_W +: NIB_W]),
      .merged (normAttr[g*NIB_W +: NIB_W])
    );
  end

  assign eitherDev  = isDevice(s1Attr) || isDevice(s2Exp);
  assign mergedAttr = eitherDev ? ((s1Attr < s2Exp) ? s1Attr : s2Exp) : normAttr;
  assign finalAttr  = (cacheDisable && !isDevice(mergedAttr)) ? ATTR_NC_BOTH : mergedAttr;

  always_comb begin
    if (isDevice(finalAttr) || finalAttr == ATTR_NC_BOTH) s2ShEff = SH_OUTER;
    else if (s2Sh == SH_RSVD)                             s2ShEff = SH_NONE;
    else                                                  s2ShEff = s2Sh;
  end

  assign shFinal = shMerge(s1Sh, s2ShEff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAttr <= '0;
      outSh   <= '0;
    end else if (strobe.capture) begin
      outAttr <= finalAttr;
      outSh   <= shFinal;
    end
  end
endmodule

// File: rtl/mem_attr_combiner.sv
module mem_attr_combiner
  import memattr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ATTR_W-1:0] s1Attr,
  input  logic [SH_W-1:0]   s1Sh,
  input  logic [CODE_W-1:0] s2MemAttr,
  input  logic [SH_W-1:0]   s2Sh,
  input  logic              cacheDisable,
  output logic              outValid,
  output logic [ATTR_W-1:0] outAttr,
  output logic [SH_W-1:0]   outSh
);
  ctlStrobe_t strobe;

  mac_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  mac_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .s1Attr       (s1Attr),
    .s1Sh         (s1Sh),
    .s2MemAttr    (s2MemAttr),
    .s2Sh         (s2Sh),
    .cacheDisable (cacheDisable),
    .outAttr      (outAttr),
    .outSh        (outSh)
  );
endmodule

// File: rtl/mem_attr_combiner_chk.sv
module mem_attr_combiner_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] s1Attr,
  input logic [1:0] s1Sh,
  input logic       cacheDisable,
  input logic       outValid,
  input logic [7:0] outAttr,
  input logic [1:0] outSh
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R1
  AST_DEVICE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && s1Attr[7:4] == 4'h0) |=> (outAttr <= $past(s1Attr))); // R4
  AST_CD_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cacheDisable) |=> (outAttr[7:4] == 4'h0 || outAttr == 8'h44)); // R7
  AST_OUTER_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && s1Sh == 2'b10) |=> (outSh == 2'b10)); // R8
  AST_NO_RSVD_SH: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSh != 2'b01)); // R8
  AST_DEVICE_OUTER: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outAttr[7:4] == 4'h0 || outAttr == 8'h44)) |-> (outSh == 2'b10)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outAttr) && $stable(outSh))); // R10
endmodule

bind mem_attr_combiner mem_attr_combiner_chk u_chk (.*);

// File: tb/mem_attr_combiner_bench.sv
`timescale 1ns/1ps
module mem_attr_combiner_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] s1Attr = '0;
  logic [1:0] s1Sh = '0;
  logic [3:0] s2MemAttr = '0;
  logic [1:0] s2Sh = '0;
  logic       cacheDisable = 1'b0;
  logic       outValid;
  logic [7:0] outAttr;
  logic [1:0] outSh;

  int checks = 0;
  int fails = 0;
  logic [9:0] expQ[$];
  string      tagQ[$];
  logic [9:0] lastExp = '0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  mem_attr_combiner u_mem_attr_combiner (
    .clk(clk), .rstN(rstN), .inValid(inValid), .s1Attr(s1Attr), .s1Sh(s1Sh),
    .s2MemAttr(s2MemAttr), .s2Sh(s2Sh), .cacheDisable(cacheDisable),
    .outValid(outValid), .outAttr(outAttr), .outSh(outSh)
  );

  // Reference model written from the requirements
  function automatic logic [7:0] refExpand(input logic [3:0] c);  // R2, R3
    case (c)
      4'h0: return 8'h00;  4'h1: return 8'h04;  4'h2: return 8'h08;  4'h3: return 8'h0C;
      4'h4: return 8'hCC;  4'h5: return 8'h44;  4'h6: return 8'h48;  4'h7: return 8'h4C;
      4'h8: return 8'h44;  4'h9: return 8'h84;  4'hA: return 8'h88;  4'hB: return 8'h8C;
      4'hC: return 8'h44;  4'hD: return 8'hC4;  4'hE: return 8'hC8;  default: return 8'hCC;
    endcase
  endfunction

  function automatic logic [3:0] refNib(input logic [3:0] a, input logic [3:0] b); // R5, R6
    logic tr;
    logic [3:0] p;
    logic [3:0] r;
    tr = (a >= 4'd1 && a <= 4'd3) || (a >= 4'd5 && a <= 4'd7);
    if (a >= 4'd1 && a <= 4'd3)      p = 4'h8 | (a & 4'h3);
    else if (a >= 4'd5 && a <= 4'd7) p = 4'hC | (a & 4'h3);
    else                             p = a;
    if ((p & 4'hC) == 4'h4 || (b & 4'hC) == 4'h4)      r = 4'h4;
    else if ((p & 4'hC) == 4'h8 || (b & 4'hC) == 4'h8) r = 4'h8;
    else                                               r = 4'hC;
    if (r != 4'h4) begin
      if (tr) r = ((p & 4'hC) == 4'h8) ? 4'h0 : 4'h4;
      r = r | (p & 4'h3);
    end
    return r;
  endfunction

  function automatic logic [9:0] refModel(input logic [7:0] a1, input logic [1:0] h1,
                                          input logic [3:0] m2, input logic [1:0] h2,
                                          input logic cd);
    logic [7:0] e2;
    logic [7:0] f;
    logic [1:0] t2;
    logic [1:0] sh;
    e2 = refExpand(m2);
    if (a1[7:4] == 4'h0 || e2[7:4] == 4'h0) f = (a1 < e2) ? a1 : e2;   // R4
    else f = {refNib(a1[7:4], e2[7:4]), refNib(a1[3:0], e2[3:0])};
    if (cd && f[7:4] != 4'h0) f = 8'h44;                               // R7
    if (f[7:4] == 4'h0 || f == 8'h44) t2 = 2'b10;                      // R9
    else if (h2 == 2'b01) t2 = 2'b00;
    else t2 = h2;
    if (h1 == 2'b10 || t2 == 2'b10) sh = 2'b10;                        // R8
    else if (h1 == 2'b11 || t2 == 2'b11) sh = 2'b11;
    else sh = 2'b00;
    return {f, sh};
  endfunction

  task automatic send(input logic [7:0] a1, input logic [1:0] h1, input logic [3:0] m2,
                      input logic [1:0] h2, input logic cd, input string tag);
    @(negedge clk);
    s1Attr = a1; s1Sh = h1; s2MemAttr = m2; s2Sh = h2; cacheDisable = cd;
    inValid = 1'b1;
    expQ.push_back(refModel(a1, h1, m2, h2, cd));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      s1Attr = 8'($urandom); s2MemAttr = 4'($urandom); cacheDisable = 1'($urandom);
    end
  endtask

  task automatic check(input logic ok, input string tag, input logic [9:0] act,
                       input logic [9:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual attr=%02h sh=%b expected attr=%02h sh=%b",
               tag, act[9:2], act[1:0], exp[9:2], exp[1:0]);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1 unexpected valid", {outAttr, outSh}, 10'h0);
        end else begin
          logic [9:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({outAttr, outSh} == e, t, {outAttr, outSh}, e);
          lastExp = e;
        end
      end else begin
        check({outAttr, outSh} == lastExp, "R10 hold while idle", {outAttr, outSh}, lastExp);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0 && outAttr == 8'h00 && outSh == 2'b00, "R1 reset state",
          {outAttr, outSh}, 10'h0);
    rstN = 1'b1;
    idle(2);

    // R2: device stage-2 codes against normal stage 1
    for (int c = 0; c < 4; c++) send(8'hFF, 2'b11, 4'(c), 2'b11, 1'b0, "R2 device expand");
    idle(1);
    // R3: every stage-2 code against write-back RAWA stage 1
    for (int c = 0; c < 16; c++) send(8'hFF, 2'b00, 4'(c), 2'b11, 1'b0, "R3 expand normal");
    idle(2);
    // R4: device against device and device against normal
    send(8'h04, 2'b00, 4'h3, 2'b00, 1'b0, "R4 dev min s1");
    send(8'h08, 2'b00, 4'h0, 2'b00, 1'b0, "R4 dev min s2");
    send(8'h0C, 2'b11, 4'hF, 2'b11, 1'b0, "R4 dev vs normal");
    // R5: weakest class per nibble, hints kept
    send(8'hAA, 2'b11, 4'hD, 2'b11, 1'b0, "R5 nibble merge");
    send(8'hEE, 2'b00, 4'hE, 2'b11, 1'b0, "R5 wt/wb merge");
    send(8'h4F, 2'b00, 4'hF, 2'b00, 1'b0, "R5 nc outer");
    // R6: transient stage-1 nibbles
    send(8'h37, 2'b11, 4'hF, 2'b11, 1'b0, "R6 transient wb");
    send(8'h76, 2'b11, 4'hA, 2'b00, 1'b0, "R6 transient vs wt");
    send(8'h15, 2'b00, 4'hF, 2'b11, 1'b0, "R6 transient nc");
    // R7 and R9 together: override forces 0x44 and outer shareability
    send(8'hFF, 2'b11, 4'hF, 2'b11, 1'b1, "R7 cd forces nc");
    send(8'hFF, 2'b11, 4'hF, 2'b11, 1'b0, "R9 same without cd");
    send(8'h08, 2'b00, 4'hF, 2'b01, 1'b1, "R7 cd leaves device");
    idle(1);
    // R8 / R9: shareability grid on normal and non-cacheable results
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        send(8'hFF, 2'(a), 4'hF, 2'(b), 1'b0, "R8 sh merge");
        send(8'h44, 2'(a), 4'hF, 2'(b), 1'b0, "R9 nc forces outer");
      end
    idle(3);
    // R10: random back-to-back stream with gaps
    for (int i = 0; i < 400; i++) begin
      send(8'($urandom), 2'($urandom), 4'($urandom), 2'($urandom), 1'($urandom),
           "R10 stream");
      if (i % 37 == 36) idle(2);
    end
    idle(4);
    done = 1'b1;
    check(expQ.size() == 0, "R1 missing outputs", 10'(expQ.size()), 10'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule